// File: doc/BRIEF.md
# Banked Interrupt Controller

This block collects up to 64 interrupt sources into a single interrupt request for a processor. The sources are split into two banks of 32. Each bank has four 32-bit registers on a plain register bus: a sticky event register, an enable mask, an acknowledge strobe and a live level view. A source is either edge-type, which is latched into its event bit, or level-type, which is reported only through the live level view. The type is fixed by a per-bank mask.

Software enables the sources it wants. When the interrupt line rises, it reads the event and level registers to find the cause and writes ones to the acknowledge register to retire edge events. Enabling an edge source whose input is already high does not create an event, because only a fresh rising edge seen while enabled is latched. The register bus is a control path with no flow control: a write takes effect on the clock edge where `wr_en_i` is high, and read data is returned one cycle after `rd_en_i`. No valid/ready handshake applies and no back-pressure exists.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset, every enable bit and every event bit is 0, `irq_o` is low and `rd_data_o` is 0.
- R2: Byte address bits [5:2] select the register and bits [1:0] are ignored. Sources 0–31 use 0x20 (event), 0x24 (enable), 0x28 (ack) and 0x2C (level). Sources 32–63 use 0x10, 0x14, 0x18 and 0x1C, with register bit n standing for source 32+n. Every other address, and the ack register itself, reads 0.
- R3: The enable register of each bank reads back exactly the last value written to it.
- R4: A level register bit equals the corresponding source input, delayed by two clock edges of synchronisation. This holds whatever the enable bit is.
- R5: An edge-type source that rises while enabled sets its event bit two edges after the first edge that sees the input high. The bit then stays set until it is acknowledged.
- R6: A rising edge on a disabled source is not latched. Setting the enable bit later, while the input is still high, sets no event bit and raises no request.
- R7: Writing a 1 to an ack bit clears that event bit. Ack bits written as 0 leave their event bits unchanged.
- R8: Sources 20–29 of the low bank are level-type, and there are none in the high bank. A level-type source never sets an event bit. It drives the request while its synchronised input is high and it is enabled.
- R9: `irq_o` is high exactly when, in either bank, some enabled source has its event bit set or is level-type with its synchronised input high.
- R10: Writes to event or level addresses change no register.
- R11: `rd_data_o` carries the addressed register for one cycle after a cycle with `rd_en_i` high, and is 0 after a cycle with `rd_en_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address within the 64-byte window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| src_i | input | 64 | Raw interrupt source inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A source change becomes visible in the level register and, for level-type sources, on `irq_o` two edges later. An edge event appears one edge after that, and read data always follows its strobe by one edge. Enable and ack writes act on the edge they are presented at, so `irq_o` reflects them at the next sample point. The bench keeps a behavioural model that moves through the same edge counts. It compares `irq_o` and `rd_data_o` against that model half a cycle after every rising edge. Its directed checks wait enough idle cycles for the synchroniser delay before reading.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int BANK_W  = 32;
  localparam int NBANK   = 2;
  localparam int ADDR_W  = 6;
  localparam int NSRC    = NBANK * BANK_W;
  localparam int SEL_LSB = 2;

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } reg_sel_e;

  // value of addr[5:4] that selects a bank
  function automatic logic [1:0] bank_slot(input int b);
    return (b == 0) ? 2'b10 : 2'b01;
  endfunction

  // level-type sources of a bank
  function automatic logic [BANK_W-1:0] bank_lvl_mask(input int b);
    return (b == 0) ? BANK_W'(32'h3FF0_0000) : '0;
  endfunction
endpackage

// File: rtl/bic_sync.sv
module bic_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~prev_q;
endmodule

// File: rtl/bic_bank.sv
module bic_bank #(
  parameter int         W        = 32,
  parameter logic [W-1:0] LVL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic         en_wr,
  input  logic         ack_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ev,
  output logic [W-1:0] en,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic         req
);
  logic [W-1:0] ev_q, en_q, ack_bits, ev_d;

  bic_sync #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (raw),
    .lvl  (lvl),
    .rise (rise)
  );

  always_comb begin
    ack_bits = ack_wr ? wdata : '0;
    // a fresh edge outranks an ack in the same cycle
    ev_d     = (ev_q & ~ack_bits) | (rise & en_q & ~LVL_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      en_q <= '0;
    end else begin
      ev_q <= ev_d;
      if (en_wr) en_q <= wdata;
    end
  end

  assign ev  = ev_q;
  assign en  = en_q;
  assign req = |((ev_q | (lvl & LVL_MASK)) & en_q);
endmodule

// File: rtl/bic_regbus.sv
module bic_regbus
  import bic_pkg::*;
#(
  parameter int W  = BANK_W,
  parameter int NB = NBANK,
  parameter int AW = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [NB-1:0][W-1:0] ev,
  input  logic [NB-1:0][W-1:0] en,
  input  logic [NB-1:0][W-1:0] lvl,
  output logic [NB-1:0]        en_wr,
  output logic [NB-1:0]        ack_wr,
  output logic [W-1:0]         rd_data
);
  logic [1:0]   slot;
  reg_sel_e     sel;
  logic [W-1:0] rd_mux;
  logic [1:0]   unused_lo;

  assign slot      = addr[AW-1:AW-2];
  assign sel       = reg_sel_e'(addr[SEL_LSB+1:SEL_LSB]);
  assign unused_lo = addr[SEL_LSB-1:0];

  always_comb begin
    rd_mux = '0;
    en_wr  = '0;
    ack_wr = '0;
    for (int b = 0; b < NB; b++) begin
      if (slot == bank_slot(b)) begin
        case (sel)
          REG_EVENT:  rd_mux = ev[b];
          REG_ENABLE: rd_mux = en[b];
          REG_LEVEL:  rd_mux = lvl[b];
          default:    rd_mux = '0;
        endcase
        en_wr[b]  = wr_en && (sel == REG_ENABLE);
        ack_wr[b] = wr_en && (sel == REG_ACK);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import bic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [BANK_W-1:0] rd_data_o,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o
);
  logic [NBANK-1:0][BANK_W-1:0] ev_b, en_b, lvl_b, rise_b;
  logic [NBANK-1:0]             en_wr, ack_wr, req_b;
  logic [NSRC-1:0]              ev_all, en_all, rise_all;

  bic_regbus #(.W(BANK_W), .NB(NBANK), .AW(ADDR_W)) u_bus (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .addr   (addr_i),
    .wr_en  (wr_en_i),
    .rd_en  (rd_en_i),
    .ev     (ev_b),
    .en     (en_b),
    .lvl    (lvl_b),
    .en_wr  (en_wr),
    .ack_wr (ack_wr),
    .rd_data(rd_data_o)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bic_bank #(.W(BANK_W), .LVL_MASK(bank_lvl_mask(b))) u_bank (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .raw   (src_i[b*BANK_W +: BANK_W]),
      .en_wr (en_wr[b]),
      .ack_wr(ack_wr[b]),
      .wdata (wr_data_i),
      .ev    (ev_b[b]),
      .en    (en_b[b]),
      .lvl   (lvl_b[b]),
      .rise  (rise_b[b]),
      .req   (req_b[b])
    );
  end

  assign ev_all   = ev_b;
  assign en_all   = en_b;
  assign rise_all = rise_b;
  assign irq_o    = |req_b;
endmodule

// File: rtl/bic_checker.sv
module bic_checker
  import bic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [BANK_W-1:0] wr_data,
  input logic              rd_en,
  input logic [BANK_W-1:0] rd_data,
  input logic [NSRC-1:0]   ev_all,
  input logic [NSRC-1:0]   en_all,
  input logic [NSRC-1:0]   rise_all
);
  localparam logic [NSRC-1:0] LVL_ALL = {bank_lvl_mask(1), bank_lvl_mask(0)};
  logic [NSRC-1:0] ack_vec;

  assign ack_vec = {(wr_en && addr[5:2] == 4'h6) ? wr_data : '0,
                    (wr_en && addr[5:2] == 4'hA) ? wr_data : '0};

  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);

  assert_en_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[5:2] == 4'h9) |=> en_all[BANK_W-1:0] == $past(wr_data));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |=> (ev_all & $past(ack_vec) & ~$past(rise_all)) == '0);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_all != '0) |=> ($past(ev_all) & ~ev_all & ~$past(ack_vec)) == '0);

  assert_only_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all != ~ev_all) |=> (ev_all & ~$past(ev_all) & ~$past(en_all)) == '0);

  assert_level_no_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all & LVL_ALL) != '0 |-> (ev_all & LVL_ALL) == '0);

  assert_ev_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr[5:2] == 4'h8 || addr[5:2] == 4'h4)) |=> $stable(en_all));
endmodule

bind bank_irq_ctrl bic_checker u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .addr    (addr_i),
  .wr_en   (wr_en_i),
  .wr_data (wr_data_i),
  .rd_en   (rd_en_i),
  .rd_data (rd_data_o),
  .ev_all  (ev_all),
  .en_all  (en_all),
  .rise_all(rise_all)
);

// File: tb/sim_bank_irq_ctrl.sv
module sim_bank_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] src = '0;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bank_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .src_i(src), .irq_o(irq)
  );

  // behavioural reference model
  localparam logic [63:0] LVL = 64'h0000_0000_3FF0_0000;
  logic [63:0] m_s1, m_s2, m_prev, m_ev, m_en, t_rise, t_ack;
  logic [31:0] m_rd;
  logic        m_irq;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a[5:2])
      4'h8: return m_ev[31:0];
      4'h9: return m_en[31:0];
      4'hB: return m_s2[31:0];
      4'h4: return m_ev[63:32];
      4'h5: return m_en[63:32];
      4'h7: return m_s2[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_ev = '0; m_en = '0; m_rd = '0;
    end else begin
      t_rise = m_s2 & ~m_prev;
      t_ack  = '0;
      if (wr_en && addr[5:2] == 4'hA) t_ack[31:0]  = wr_data;
      if (wr_en && addr[5:2] == 4'h6) t_ack[63:32] = wr_data;
      m_rd = rd_en ? m_read(addr) : 32'h0;
      m_ev = (m_ev & ~t_ack) | (t_rise & m_en & ~LVL);
      if (wr_en && addr[5:2] == 4'h9) m_en[31:0]  = wr_data;
      if (wr_en && addr[5:2] == 4'h5) m_en[63:32] = wr_data;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = src;
    end
  end
  assign m_irq = |((m_ev | (m_s2 & LVL)) & m_en);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9", "irq vs model", {31'b0, irq}, {31'b0, m_irq});
      check("R11", "rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); #1; addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); #1; addr = a; rd_en = 1;
    @(negedge clk); d = rd_data; #1; rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R1 watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst_n = 1;

    // R1 reset state
    check("R1", "irq after reset", {31'b0, irq}, 32'h0);
    rd(6'h24, v); check("R1", "low enable", v, 32'h0);
    rd(6'h14, v); check("R1", "high enable", v, 32'h0);
    rd(6'h20, v); check("R1", "low event", v, 32'h0);

    // R3 enable readback, R2 map and unmapped addresses
    wr(6'h24, 32'hA5A5_0F0F); wr(6'h14, 32'h1234_5678);
    rd(6'h24, v); check("R3", "low enable readback", v, 32'hA5A5_0F0F);
    rd(6'h15, v); check("R2", "high enable, low bits ignored", v, 32'h1234_5678);
    rd(6'h00, v); check("R2", "unmapped 0x00", v, 32'h0);
    rd(6'h30, v); check("R2", "unmapped 0x30", v, 32'h0);
    rd(6'h28, v); check("R2", "ack reads zero", v, 32'h0);
    wr(6'h24, 32'h0); wr(6'h14, 32'h0);

    // R4 level view regardless of enable
    src[3] = 1; src[40] = 1;
    idle(3);
    rd(6'h2C, v); check("R4", "low level", v, 32'h0000_0008);
    rd(6'h1C, v); check("R4", "high level", v, 32'h0000_0100);
    rd(6'h20, v); check("R6", "disabled edge not latched", v, 32'h0);

    // R6 enable while input already high
    wr(6'h24, 32'h0000_0008);
    idle(3);
    rd(6'h20, v); check("R6", "no event on late enable", v, 32'h0);
    check("R6", "no request on late enable", {31'b0, irq}, 32'h0);

    // R5 edge latch in both banks
    src[3] = 0; idle(4);
    src[3] = 1; idle(4);
    rd(6'h20, v); check("R5", "low edge latched", v, 32'h0000_0008);
    check("R5", "irq from edge", {31'b0, irq}, 32'h1);
    wr(6'h14, 32'h0000_0200);
    src[41] = 1; idle(4);
    rd(6'h10, v); check("R5", "high edge latched", v, 32'h0000_0200);
    idle(2);
    rd(6'h10, v); check("R5", "event sticky", v, 32'h0000_0200);

    // R7 acknowledge, R9 request across banks
    wr(6'h28, 32'h0);
    rd(6'h20, v); check("R7", "zero ack no effect", v, 32'h0000_0008);
    wr(6'h28, 32'h0000_0008);
    rd(6'h20, v); check("R7", "ack clears", v, 32'h0);
    check("R9", "high bank still requests", {31'b0, irq}, 32'h1);
    wr(6'h18, 32'h0000_0200);
    check("R7", "irq low after both acks", {31'b0, irq}, 32'h0);
    rd(6'h10, v); check("R7", "high event cleared", v, 32'h0);

    // R8 level-type source
    wr(6'h24, 32'h0040_0000);
    src[22] = 1; idle(3);
    check("R8", "level source requests", {31'b0, irq}, 32'h1);
    rd(6'h20, v); check("R8", "level source no event", v, 32'h0);
    src[22] = 0; idle(3);
    check("R8", "request drops with input", {31'b0, irq}, 32'h0);

    // R10 writes to event and level ignored
    wr(6'h20, 32'hFFFF_FFFF); wr(6'h2C, 32'hFFFF_FFFF);
    rd(6'h24, v); check("R10", "enable untouched", v, 32'h0040_0000);
    rd(6'h20, v); check("R10", "event untouched", v, 32'h0);
    rd(6'h2C, v); check("R10", "level untouched", v, 32'h0000_0008);

    // R11 idle read data
    idle(1);
    check("R11", "rd_data zero when idle", rd_data, 32'h0);

    // mixed traffic, compared cycle by cycle against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      if (i % 3 == 0) src = {$urandom, $urandom};
      wr_en   = ($urandom % 4 == 0);
      rd_en   = ($urandom % 2 == 0);
      addr    = 6'($urandom);
      wr_data = $urandom;
    end
    @(negedge clk); #1; wr_en = 0; rd_en = 0;
    idle(4);
    finish_run();
  end
endmodule